// File: doc/BRIEF.md
# Sector EDC CRC-32 Checker

This block verifies the 32-bit error detection code of a CD-ROM data sector once error correction of that sector has finished. The corrected sector is streamed into it one byte per clock, starting with the first sync byte and ending with the last of the four stored EDC bytes. A start marker on the first byte opens a new frame. A mode input, sampled with that first byte, selects whether the sector is mode 1 or mode 2.

As the bytes go past, the block runs a CRC over the range that the mode covers, continues it through the stored EDC, and captures the 4-byte header and the 8-byte subheader into registers. One cycle after the last EDC byte it pulses a decode interrupt and presents a pass/fail verdict. The verdict stays put until the next frame start. Bytes that arrive after the EDC and before the next start are ignored.

The controller uses the interrupt to fetch the verdict and the captured header and subheader of the sector it has just decoded.

Top module: `edc_sector_checker`

## Requirements
- R1: After reset, `done_irq`, `result_valid`, `edc_fail`, `header` and `subheader` are all zero.
- R2: The CRC uses the generator x^32+x^31+x^16+x^15+x^4+x^3+x+1, bits taken LSB first, with a zero start value. In a mode 1 sector, byte indices 0 to 2063 are covered, and indices 2064 to 2067 hold the stored EDC with the least significant byte first. For a sector whose stored EDC matches, `done_irq` is high for the cycle after the byte at index 2067 is taken, `result_valid` is 1 and `edc_fail` is 0.
- R3: In mode 1 the 12 sync bytes (indices 0 to 11) are inside the check, so changing one of them sets `edc_fail`.
- R4: In mode 2 (`in_mode2`=1 on the start byte) the check covers indices 16 to 2071 and the EDC sits at 2072 to 2075. Changing a sync or header byte has no effect on the verdict, while changing a subheader byte sets `edc_fail`.
- R5: A stored EDC byte that differs from the computed CRC sets `edc_fail`.
- R6: `header` holds the bytes at indices 12 to 15, with index 12 in bits 7:0 and index 15 in bits 31:24.
- R7: In mode 2, `subheader` holds the bytes at indices 16 to 23, with index 16 in bits 7:0. In mode 1 it reads zero.
- R8: `done_irq` lasts exactly one cycle. `result_valid` and `edc_fail` then hold until a start byte is taken, and the start byte clears both on the following cycle.
- R9: Cycles with `in_valid` low stall the frame without changing its verdict or captured fields.
- R10: Bytes with `in_valid` high that arrive after the last EDC byte and before the next start byte raise no interrupt and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sector byte is present on `in_data` |
| in_first | input | 1 | This byte is index 0 of a new frame |
| in_mode2 | input | 1 | Sector mode, sampled with the start byte (1 = mode 2) |
| in_data | input | 8 | Sector byte |
| done_irq | output | 1 | One-cycle decode interrupt |
| result_valid | output | 1 | Verdict of the last frame is available |
| edc_fail | output | 1 | Computed CRC and stored EDC disagree |
| header | output | 32 | Captured header bytes |
| subheader | output | 64 | Captured subheader bytes (mode 2) |

## Verification
The assertions assume that `in_first` is only meaningful together with `in_valid`, and that a new start byte never lands in the same cycle as the final EDC byte of the previous frame. The bench keeps to these assumptions. It drives every frame from index 0 with the start marker on its first byte only, and it lets at least one cycle pass after the last EDC byte before the next frame begins. Idle gaps and trailing junk bytes are driven with the start marker held low, so they probe the stall and ignore paths without breaking these assumptions.

// File: rtl/edc_pkg.sv
package edc_pkg;

  // Reflected form of x^32+x^31+x^16+x^15+x^4+x^3+x+1
  localparam logic [31:0] EDC_POLY_REFL = 32'hD801_8001;

  // Fold one byte into the register, least significant bit first
  function automatic logic [31:0] edc_fold_byte(input logic [31:0] crc_in,
                                                input logic [7:0]  b);
    logic [31:0] c;
    c = crc_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ EDC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/edc_crc_unit.sv
module edc_crc_unit
  import edc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        restart,
  input  logic        feed,
  input  logic [7:0]  din,
  output logic [31:0] crc_next
);

  logic [31:0] crc_q;
  logic [31:0] base;

  always_comb begin
    base     = restart ? 32'd0 : crc_q;
    crc_next = feed ? edc_fold_byte(base, din) : base;
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= 32'd0;
    else     crc_q <= crc_next;
  end

endmodule

// File: rtl/edc_frame_seq.sv
module edc_frame_seq #(
  parameter int SYNC_BYTES = 12,
  parameter int HDR_BYTES  = 4,
  parameter int SUB_BYTES  = 8,
  parameter int DATA_BYTES = 2048,
  parameter int EDC_BYTES  = 4,
  parameter int IW         = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_mode2,
  output logic          take,
  output logic          start,
  output logic          mode_cur,
  output logic [IW-1:0] idx_cur,
  output logic          feed,
  output logic          last
);

  localparam int M1_BEG = 0;
  localparam int M1_END = SYNC_BYTES + HDR_BYTES + DATA_BYTES;
  localparam int M2_BEG = SYNC_BYTES + HDR_BYTES;
  localparam int M2_END = M2_BEG + SUB_BYTES + DATA_BYTES;

  localparam logic [IW-1:0] M1_LO   = IW'(M1_BEG);
  localparam logic [IW-1:0] M1_HI   = IW'(M1_END + EDC_BYTES);
  localparam logic [IW-1:0] M2_LO   = IW'(M2_BEG);
  localparam logic [IW-1:0] M2_HI   = IW'(M2_END + EDC_BYTES);
  localparam logic [IW-1:0] M1_LAST = IW'(M1_END + EDC_BYTES - 1);
  localparam logic [IW-1:0] M2_LAST = IW'(M2_END + EDC_BYTES - 1);

  logic [IW-1:0] cnt_q;
  logic          mode_q;
  logic          active_q;
  logic          active_cur;
  logic [IW-1:0] lo, hi, last_idx;

  always_comb begin
    active_cur = in_first | active_q;
    take       = in_valid & active_cur;
    start      = in_valid & in_first;
    idx_cur    = in_first ? '0 : cnt_q;
    mode_cur   = in_first ? in_mode2 : mode_q;
    lo         = mode_cur ? M2_LO : M1_LO;
    hi         = mode_cur ? M2_HI : M1_HI;
    last_idx   = mode_cur ? M2_LAST : M1_LAST;
    feed       = take && (idx_cur >= lo) && (idx_cur < hi);
    last       = take && (idx_cur == last_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (take) begin
      cnt_q    <= idx_cur + 1'b1;
      mode_q   <= mode_cur;
      active_q <= ~last;
    end
  end

endmodule

// File: rtl/edc_capture.sv
module edc_capture #(
  parameter int HDR_BYTES = 4,
  parameter int SUB_BYTES = 8,
  parameter int HDR_AT    = 12,
  parameter int SUB_AT    = 16,
  parameter int IW        = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take,
  input  logic                   start,
  input  logic                   mode2,
  input  logic [IW-1:0]          idx,
  input  logic [7:0]             din,
  output logic [HDR_BYTES*8-1:0] hdr_q,
  output logic [SUB_BYTES*8-1:0] sub_q
);

  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_hdr
    localparam logic [IW-1:0] AT = IW'(HDR_AT + i);
    always_ff @(posedge clk) begin
      if (rst || start)            hdr_q[i*8 +: 8] <= 8'd0;
      else if (take && idx == AT)  hdr_q[i*8 +: 8] <= din;
    end
  end

  for (genvar i = 0; i < SUB_BYTES; i++) begin : g_sub
    localparam logic [IW-1:0] AT = IW'(SUB_AT + i);
    always_ff @(posedge clk) begin
      if (rst || start)                     sub_q[i*8 +: 8] <= 8'd0;
      else if (take && mode2 && idx == AT)  sub_q[i*8 +: 8] <= din;
    end
  end

endmodule

// File: rtl/edc_sector_checker.sv
module edc_sector_checker #(
  parameter int SYNC_BYTES = 12,
  parameter int HDR_BYTES  = 4,
  parameter int SUB_BYTES  = 8,
  parameter int DATA_BYTES = 2048,
  parameter int EDC_BYTES  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_first,
  input  logic                   in_mode2,
  input  logic [7:0]             in_data,
  output logic                   done_irq,
  output logic                   result_valid,
  output logic                   edc_fail,
  output logic [HDR_BYTES*8-1:0] header,
  output logic [SUB_BYTES*8-1:0] subheader
);

  localparam int FRAME_MAX = SYNC_BYTES + HDR_BYTES + SUB_BYTES + DATA_BYTES + EDC_BYTES;
  localparam int IW        = $clog2(FRAME_MAX + 1);

  logic          take, start, mode_cur, feed, last;
  logic [IW-1:0] idx_cur;
  logic [31:0]   crc_next;

  edc_frame_seq #(
    .SYNC_BYTES(SYNC_BYTES), .HDR_BYTES(HDR_BYTES), .SUB_BYTES(SUB_BYTES),
    .DATA_BYTES(DATA_BYTES), .EDC_BYTES(EDC_BYTES), .IW(IW)
  ) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_mode2(in_mode2), .take(take), .start(start), .mode_cur(mode_cur),
    .idx_cur(idx_cur), .feed(feed), .last(last)
  );

  edc_crc_unit u_crc (
    .clk(clk), .rst(rst), .restart(start), .feed(feed),
    .din(in_data), .crc_next(crc_next)
  );

  edc_capture #(
    .HDR_BYTES(HDR_BYTES), .SUB_BYTES(SUB_BYTES),
    .HDR_AT(SYNC_BYTES), .SUB_AT(SYNC_BYTES + HDR_BYTES), .IW(IW)
  ) u_cap (
    .clk(clk), .rst(rst), .take(take), .start(start), .mode2(mode_cur),
    .idx(idx_cur), .din(in_data), .hdr_q(header), .sub_q(subheader)
  );

  // Running the CRC through the stored EDC leaves a zero residue on a match
  always_ff @(posedge clk) begin
    if (rst) begin
      done_irq     <= 1'b0;
      result_valid <= 1'b0;
      edc_fail     <= 1'b0;
    end else begin
      done_irq <= last;
      if (start) begin
        result_valid <= 1'b0;
        edc_fail     <= 1'b0;
      end else if (last) begin
        result_valid <= 1'b1;
        edc_fail     <= (crc_next != 32'd0);
      end
    end
  end

endmodule

// File: rtl/edc_sector_checker_sva.sv
module edc_sector_checker_sva #(
  parameter int HW = 32,
  parameter int SW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_first,
  input logic          done_irq,
  input logic          result_valid,
  input logic          edc_fail,
  input logic [HW-1:0] header,
  input logic [SW-1:0] subheader
);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  assert_irq_has_result_R8: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> result_valid);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |=> (!result_valid && !edc_fail));

  assert_verdict_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !(in_valid && in_first)) |=> (result_valid && $stable(edc_fail)));

  assert_fail_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    edc_fail |-> result_valid);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(header) && $stable(subheader)));

endmodule

bind edc_sector_checker edc_sector_checker_sva #(
  .HW(HDR_BYTES*8), .SW(SUB_BYTES*8)
) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
  .done_irq(done_irq), .result_valid(result_valid), .edc_fail(edc_fail),
  .header(header), .subheader(subheader)
);

// File: tb/tb_edc_sector_checker.sv
`timescale 1ns/1ps
module tb_edc_sector_checker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_first = 1'b0, in_mode2 = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        done_irq, result_valid, edc_fail;
  logic [31:0] header;
  logic [63:0] subheader;

  int checks = 0, errors = 0;
  logic [7:0] sec [0:2075];
  int sec_len;

  always #2 clk = ~clk;

  edc_sector_checker dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_mode2(in_mode2), .in_data(in_data), .done_irq(done_irq),
    .result_valid(result_valid), .edc_fail(edc_fail),
    .header(header), .subheader(subheader)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // CRC per the requirement: generator bits 32,31,16,15,4,3,1,0, LSB first, zero start
  function automatic logic [31:0] ref_crc(input int b, input int e);
    logic [31:0] c = 32'd0;
    for (int i = b; i < e; i++) begin
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ sec[i][k];
        c  = c >> 1;
        if (fb) c = c ^ 32'hD801_8001;
      end
    end
    return c;
  endfunction

  task automatic build(input bit m2, input int seed);
    int b, e;
    logic [31:0] c;
    sec_len = m2 ? 2076 : 2068;
    for (int i = 0; i < 2076; i++) sec[i] = 8'((i * 7) ^ (seed * 29) ^ (i >> 4));
    sec[0] = 8'h00; sec[11] = 8'h00;
    for (int i = 1; i < 11; i++) sec[i] = 8'hFF;
    b = m2 ? 16 : 0;
    e = m2 ? 2072 : 2064;
    c = ref_crc(b, e);
    for (int k = 0; k < 4; k++) sec[e + k] = c[k*8 +: 8];
  endtask

  task automatic send(input bit m2, input int gap, output int early, output bit irq_end);
    early = 0;
    for (int i = 0; i < sec_len; i++) begin
      @(negedge clk);
      if (done_irq) early++;
      if (gap > 0 && (i % gap) == gap - 1) begin
        in_valid = 1'b0; in_first = 1'b0;
        @(negedge clk);
        if (done_irq) early++;
      end
      in_valid = 1'b1; in_first = (i == 0); in_mode2 = m2; in_data = sec[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    irq_end = done_irq;
  endtask

  task automatic t_reset();
    chk(done_irq == 0 && result_valid == 0 && edc_fail == 0, "R1 flags",
        {61'd0, done_irq, result_valid, edc_fail}, 0);
    chk(header == 0 && subheader == 0, "R1 fields", header ^ subheader, 0);
  endtask

  task automatic t_mode1_good();
    int early; bit ie;
    build(0, 3);
    send(0, 0, early, ie);
    chk(early == 0, "R2 no early irq", early, 0);
    chk(ie == 1, "R2 irq after last EDC byte", ie, 1);
    chk(result_valid == 1 && edc_fail == 0, "R2 pass verdict", {result_valid, edc_fail}, 2'b10);
    chk(header == {sec[15], sec[14], sec[13], sec[12]}, "R6 header", header,
        {sec[15], sec[14], sec[13], sec[12]});
    chk(subheader == 0, "R7 mode1 subheader zero", subheader, 0);
    @(negedge clk);
    chk(done_irq == 0, "R8 irq one cycle", done_irq, 0);
  endtask

  task automatic t_trailing();
    logic [31:0] h;
    int seen = 0;
    h = header;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done_irq) seen++;
      in_valid = 1'b1; in_first = 1'b0; in_data = 8'(i * 37 + 5);
    end
    @(negedge clk);
    if (done_irq) seen++;
    in_valid = 1'b0;
    @(negedge clk);
    if (done_irq) seen++;
    chk(seen == 0, "R10 no irq on trailing bytes", seen, 0);
    chk(result_valid == 1 && edc_fail == 0 && header == h, "R10 outputs unchanged",
        {result_valid, edc_fail}, 2'b10);
  endtask

  task automatic t_mode1_sync_err();
    int early; bit ie;
    build(0, 5);
    sec[4] = sec[4] ^ 8'h10;
    send(0, 0, early, ie);
    chk(ie == 1 && edc_fail == 1, "R3 sync byte covered", {ie, edc_fail}, 2'b11);
  endtask

  task automatic t_start_clears();
    @(negedge clk);
    in_valid = 1'b1; in_first = 1'b1; in_mode2 = 1'b0; in_data = 8'h00;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    chk(result_valid == 0 && edc_fail == 0, "R8 start clears verdict",
        {result_valid, edc_fail}, 0);
  endtask

  task automatic t_mode2_good();
    int early; bit ie;
    logic [63:0] s;
    build(1, 7);
    send(1, 0, early, ie);
    chk(ie == 1 && early == 0 && edc_fail == 0 && result_valid == 1, "R4 mode2 pass",
        {ie, edc_fail, result_valid}, 3'b101);
    for (int i = 0; i < 8; i++) s[i*8 +: 8] = sec[16 + i];
    chk(subheader == s, "R7 mode2 subheader", subheader, s);
    chk(header == {sec[15], sec[14], sec[13], sec[12]}, "R6 mode2 header", header,
        {sec[15], sec[14], sec[13], sec[12]});
  endtask

  task automatic t_mode2_hdr_change();
    int early; bit ie;
    build(1, 9);
    sec[2]  = sec[2] ^ 8'h01;
    sec[13] = sec[13] ^ 8'h80;
    send(1, 0, early, ie);
    chk(ie == 1 && edc_fail == 0, "R4 mode2 ignores sync and header", {ie, edc_fail}, 2'b10);
  endtask

  task automatic t_mode2_sub_change();
    int early; bit ie;
    build(1, 11);
    sec[20] = sec[20] ^ 8'h04;
    send(1, 0, early, ie);
    chk(ie == 1 && edc_fail == 1, "R4 mode2 covers subheader", {ie, edc_fail}, 2'b11);
  endtask

  task automatic t_edc_corrupt();
    int early; bit ie;
    build(0, 13);
    sec[2067] = sec[2067] ^ 8'h40;
    send(0, 0, early, ie);
    chk(ie == 1 && edc_fail == 1, "R5 stored EDC mismatch", {ie, edc_fail}, 2'b11);
    build(1, 15);
    sec[2072] = sec[2072] ^ 8'h01;
    send(1, 0, early, ie);
    chk(ie == 1 && edc_fail == 1, "R5 low EDC byte mismatch", {ie, edc_fail}, 2'b11);
  endtask

  task automatic t_gaps();
    int early; bit ie;
    logic [63:0] s;
    build(1, 17);
    send(1, 5, early, ie);
    for (int i = 0; i < 8; i++) s[i*8 +: 8] = sec[16 + i];
    chk(early == 0 && ie == 1 && edc_fail == 0, "R9 stalls keep verdict",
        {early[7:0], ie, edc_fail}, 2);
    chk(subheader == s, "R9 stalls keep subheader", subheader, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode1_good();
    t_trailing();
    t_mode1_sync_err();
    t_start_clears();
    t_mode2_good();
    t_mode2_hdr_change();
    t_mode2_sub_change();
    t_edc_corrupt();
    t_gaps();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule